// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

A synthesizable behavioural model of a synchronous static RAM whose word is four 9-bit byte lanes (36 bits) and whose depth is set by an address-width parameter. On each rising clock edge it samples an address, three chip-select inputs, a read/write select, a load/advance select, an active-low clock enable and four active-low byte write enables. A load cycle starts a single access or the first beat of a short burst. Each following advance cycle steps an internal 2-bit beat counter, so the next three addresses come from the block and not from the address pins.

Write data arrives one edge after its address. Read data flows combinationally out of the array from the address taken on the last edge. Because of this, a read can follow a write, and a write can follow a read, on adjacent cycles with no idle cycle between them. Holding the clock enable high stretches the current cycle: nothing inside the model moves. The model is meant to stand in for such a memory in chip-level simulation, with a small depth.

Top module: `ftzbt_sram`

## Requirements
- R1: Address and control inputs take effect only at a rising clock edge. Changing them between edges does not alter the read output.
- R2: While `clkEnN` is high, each edge is ignored. The access state, the pending write, the array and the read output all hold.
- R3: On a load cycle (`advLdN` low) with the chip selected, `rdWrN` high starts a read and `rdWrN` low starts a write.
- R4: On advance cycles (`advLdN` high), an access keeps the read/write type it was loaded with, whatever `rdWrN` is.
- R5: With `linearMode` high, beat k of a burst loaded at address A uses address bits [1:0] = (A[1:0] + k) mod 4. The upper address bits stay as loaded.
- R6: With `linearMode` low, beat k uses address bits [1:0] = A[1:0] XOR k. The upper address bits stay as loaded.
- R7: `byteWeN[i]` low writes lane i, which is data bits [9i+8:9i]. A lane whose enable is high keeps its contents. All four low writes the whole word. The enables are taken in the same cycle as the address of that beat.
- R8: Write data is taken from `wrData` at the edge after its address cycle. A read of the same address loaded at that edge returns the new data with no idle cycle.
- R9: During a selected read, `rdData` shows the word at the current address as soon as that address has been registered. `rdData` is zero when `outEnN` is high, when no access is active, or during a write.
- R10: An advance cycle with no active access starts nothing: no write happens and `rdData` stays zero.
- R11: The chip is selected only when `ceN` is low, `ce2` is high and `ce2N` is low. A load cycle without selection ends any burst and starts no access.
- R12: With `rstN` low at an edge, the block goes idle and `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset of the access state |
| clkEnN | input | 1 | Active-low clock enable; high stretches the current cycle |
| ceN | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| ce2N | input | 1 | Second active-low chip select |
| rdWrN | input | 1 | 1 = read, 0 = write; used on load cycles only |
| advLdN | input | 1 | 0 = load a new address, 1 = advance the burst |
| byteWeN | input | 4 | Active-low byte write enables, bit i for lane i |
| linearMode | input | 1 | 1 = linear burst order, 0 = interleaved order |
| outEnN | input | 1 | Active-low output enable for read data |
| addr | input | ADDR_W | Word address |
| wrData | input | 36 | Write data, taken one edge after its address |
| rdData | output | 36 | Flow-through read data, zero when not driven |

## Verification
The assertions assume that `linearMode` does not change while a burst is advancing. The stimulus therefore sets the burst order only after the load edge of each burst and holds it until the next load. They also assume that the control inputs carry known values from the first edge on, which the bench ensures by driving every input before reset is released. The sweeps write all addresses with linear bursts. They read every start address in both orders, and try all sixteen byte-enable masks with a read placed directly after each write.

// File: rtl/ftzbt_pkg.sv
package ftzbt_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             commitWr;
    logic [LANES-1:0] laneMask;
    logic             driveRd;
  } ctl_strobe_t;
endpackage

// File: rtl/ftzbt_burst.sv
module ftzbt_burst
  import ftzbt_pkg::*;
#(
  parameter int BW = BEAT_W
) (
  input  logic [BW-1:0] startLow,
  input  logic [BW-1:0] beat,
  input  logic          linearMode,
  output logic [BW-1:0] lowBits
);
  logic [BW-1:0] linNext;
  logic [BW-1:0] xorNext;

  assign linNext = startLow + beat;   // wraps inside the block
  assign xorNext = startLow ^ beat;

  always_comb begin
    lowBits = linearMode ? linNext : xorNext;
  end
endmodule

// File: rtl/ftzbt_ctrl.sv
module ftzbt_ctrl
  import ftzbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              ceN,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              rdWrN,
  input  logic              advLdN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic              linearMode,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addr,
  output ctl_strobe_t       stb,
  output logic [ADDR_W-1:0] curAddr,
  output logic              activeQ,
  output logic              writeQ
);
  localparam int HI_W = ADDR_W - BEAT_W;

  acc_e              accQ;
  logic [ADDR_W-1:0] baseQ;
  logic [BEAT_W-1:0] beatQ;
  logic [LANES-1:0]  maskQ;
  logic [BEAT_W-1:0] lowBits;

  logic stepEn;
  logic selected;
  logic isLoad;

  assign stepEn   = !clkEnN;
  assign selected = !ceN && ce2 && !ce2N;
  assign isLoad   = !advLdN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      accQ    <= ACC_RD;
      baseQ   <= '0;
      beatQ   <= '0;
      maskQ   <= '0;
    end else if (stepEn) begin
      if (isLoad) begin
        activeQ <= selected;
        if (selected) begin
          accQ  <= rdWrN ? ACC_RD : ACC_WR;
          baseQ <= addr;
          beatQ <= '0;
          maskQ <= ~byteWeN;
        end
      end else if (activeQ) begin
        beatQ <= beatQ + 1'b1;
        maskQ <= ~byteWeN;
      end
    end
  end

  ftzbt_burst #(.BW(BEAT_W)) burst_i (
    .startLow  (baseQ[BEAT_W-1:0]),
    .beat      (beatQ),
    .linearMode(linearMode),
    .lowBits   (lowBits)
  );

  logic [HI_W-1:0] hiBits;
  assign hiBits  = baseQ[ADDR_W-1:BEAT_W];
  assign curAddr = {hiBits, lowBits};
  assign writeQ  = (accQ == ACC_WR);

  always_comb begin
    stb.commitWr = stepEn && activeQ && (accQ == ACC_WR);
    stb.laneMask = maskQ;
    stb.driveRd  = activeQ && (accQ == ACC_RD) && !outEnN;
  end
endmodule

// File: rtl/ftzbt_data.sv
module ftzbt_data
  import ftzbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  ctl_strobe_t       stb,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.commitWr) begin
      for (int l = 0; l < LANES; l++) begin
        if (stb.laneMask[l]) begin
          mem[curAddr][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
        end
      end
    end
  end

  always_comb begin
    rdData = stb.driveRd ? mem[curAddr] : '0;
  end
endmodule

// File: rtl/ftzbt_sram.sv
module ftzbt_sram
  import ftzbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              ceN,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              rdWrN,
  input  logic              advLdN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic              linearMode,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  ctl_strobe_t       stb;
  logic [ADDR_W-1:0] curAddr;
  logic              activeQ;
  logic              writeQ;

  ftzbt_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .clkEnN    (clkEnN),
    .ceN       (ceN),
    .ce2       (ce2),
    .ce2N      (ce2N),
    .rdWrN     (rdWrN),
    .advLdN    (advLdN),
    .byteWeN   (byteWeN),
    .linearMode(linearMode),
    .outEnN    (outEnN),
    .addr      (addr),
    .stb       (stb),
    .curAddr   (curAddr),
    .activeQ   (activeQ),
    .writeQ    (writeQ)
  );

  ftzbt_data #(.ADDR_W(ADDR_W)) data_i (
    .clk    (clk),
    .stb    (stb),
    .curAddr(curAddr),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: rtl/ftzbt_sram_chk.sv
module ftzbt_sram_chk
  import ftzbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              ceN,
  input logic              ce2,
  input logic              ce2N,
  input logic              rdWrN,
  input logic              advLdN,
  input logic              linearMode,
  input logic              outEnN,
  input logic [WORD_W-1:0] rdData,
  input logic [ADDR_W-1:0] curAddr,
  input logic              activeQ,
  input logic              writeQ
);
  logic sel;
  assign sel = !ceN && ce2 && !ce2N;

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(curAddr) && $stable(activeQ) && $stable(writeQ));

  p_load_type_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && sel) |=> activeQ && (writeQ == !$past(rdWrN)));

  p_type_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && advLdN && activeQ) |=> activeQ && $stable(writeQ));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && advLdN && activeQ && linearMode) |=>
      (curAddr[1:0] == 2'($past(curAddr[1:0]) + 2'd1)) &&
      $stable(curAddr[ADDR_W-1:2]));

  p_oe_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outEnN || !activeQ || writeQ) |-> (rdData == '0));

  p_adv_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && advLdN && !activeQ) |=> !activeQ);

  p_deselect_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && !sel) |=> !activeQ);
endmodule

bind ftzbt_sram ftzbt_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .clkEnN    (clkEnN),
  .ceN       (ceN),
  .ce2       (ce2),
  .ce2N      (ce2N),
  .rdWrN     (rdWrN),
  .advLdN    (advLdN),
  .linearMode(linearMode),
  .outEnN    (outEnN),
  .rdData    (rdData),
  .curAddr   (curAddr),
  .activeQ   (activeQ),
  .writeQ    (writeQ)
);

// File: tb/ftzbt_sram_tb.sv
`timescale 1ns/1ps
module ftzbt_sram_tb_top;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          clkEnN, ceN, ce2, ce2N, rdWrN, advLdN, linearMode, outEnN;
  logic [3:0]    byteWeN;
  logic [AW-1:0] addr;
  logic [35:0]   wrData;
  logic [35:0]   rdData;

  logic [35:0] model [DEPTH];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  ftzbt_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .ceN(ceN), .ce2(ce2), .ce2N(ce2N),
    .rdWrN(rdWrN), .advLdN(advLdN), .byteWeN(byteWeN), .linearMode(linearMode),
    .outEnN(outEnN), .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [35:0] pat(int a);
    return (36'(a) * 36'h0_0F1E_2D3B) ^ 36'h5_A5A5_A5A5;
  endfunction

  function automatic int beatAddr(int start, int k, bit lin);
    int lo;
    lo = lin ? ((start + k) & 3) : ((start & 3) ^ k);
    return (start & ~3) | lo;
  endfunction

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: rdData=%h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic loadOp(int a, bit wr, logic [3:0] be);
    advLdN = 1'b0; rdWrN = !wr; addr = AW'(a); byteWeN = be;
    tick();
  endtask

  task automatic advOp(logic [3:0] be);
    advLdN = 1'b1; byteWeN = be;
    tick();
  endtask

  task automatic deselOp(int v);
    advLdN = 1'b0;
    if (v == 0) ceN = 1'b1;
    else if (v == 1) ce2 = 1'b0;
    else ce2N = 1'b1;
    tick();
    ceN = 1'b0; ce2 = 1'b1; ce2N = 1'b0;
  endtask

  task automatic readBurst(int start, bit lin);
    loadOp(start, 1'b0, 4'hF);
    linearMode = lin;
    #0.5;
    check("R9", rdData, model[start]);
    for (int k = 1; k < 4; k++) begin
      int a;
      a = beatAddr(start, k, lin);
      advOp(4'hF);
      check(lin ? "R5" : "R6", rdData, model[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int prev;
    rstN = 1'b0; clkEnN = 1'b0; ceN = 1'b0; ce2 = 1'b1; ce2N = 1'b0;
    rdWrN = 1'b1; advLdN = 1'b1; byteWeN = 4'hF; linearMode = 1'b1;
    outEnN = 1'b0; addr = '0; wrData = '0;
    tick(); tick();
    check("R12", rdData, 36'h0);
    rstN = 1'b1;

    // Fill every word with linear write bursts
    prev = 0;
    for (int b = 0; b < DEPTH / 4; b++) begin
      for (int k = 0; k < 4; k++) begin
        int a;
        a = b * 4 + k;
        wrData = pat(prev);
        if (k == 0) loadOp(a, 1'b1, 4'h0);
        else advOp(4'h0);
        prev = a;
      end
    end
    wrData = pat(prev);
    deselOp(0);
    for (int a = 0; a < DEPTH; a++) model[a] = pat(a);
    check("R11", rdData, 36'h0);

    // Every start address in both burst orders
    for (int s = 0; s < DEPTH; s++) readBurst(s, 1'b1);
    for (int s = 0; s < DEPTH; s++) readBurst(s, 1'b0);
    linearMode = 1'b1;

    // R1: inputs changed between edges do not move the output
    loadOp(30, 1'b0, 4'hF);
    addr = AW'(40); rdWrN = 1'b0; #1;
    check("R1", rdData, model[30]);

    // R7 / R8: all byte masks, read placed right after each write
    for (int m = 0; m < 16; m++) begin
      logic [35:0] nv;
      nv = 36'h9_ABCD_EF01 ^ (36'(m) * 36'h0_1357_9BDF);
      loadOp(5, 1'b1, 4'(m));
      wrData = nv;
      loadOp(5, 1'b0, 4'hF);
      for (int l = 0; l < 4; l++)
        if (!m[l]) model[5][l*9 +: 9] = nv[l*9 +: 9];
      check("R7", rdData, model[5]);
    end
    check("R8", rdData, model[5]);

    // R3: write then read on adjacent cycles at a new address
    loadOp(6, 1'b1, 4'h0);
    wrData = 36'h1_2345_6789;
    loadOp(6, 1'b0, 4'hF);
    model[6] = 36'h1_2345_6789;
    check("R3", rdData, model[6]);

    // R2: stall during a read burst
    loadOp(8, 1'b0, 4'hF);
    clkEnN = 1'b1; advLdN = 1'b0; addr = AW'(20); rdWrN = 1'b0;
    tick(); tick();
    check("R2", rdData, model[8]);
    clkEnN = 1'b0; rdWrN = 1'b1;
    advOp(4'hF);
    check("R2", rdData, model[9]);

    // R2: stall between write address and write data
    loadOp(12, 1'b1, 4'h0);
    clkEnN = 1'b1; wrData = 36'hF_0000_000F;
    tick(); tick();
    clkEnN = 1'b0; wrData = 36'h3_C3C3_C3C3;
    loadOp(12, 1'b0, 4'hF);
    model[12] = 36'h3_C3C3_C3C3;
    check("R2", rdData, model[12]);

    // R4: read burst ignores rdWrN on advances
    loadOp(16, 1'b0, 4'hF);
    rdWrN = 1'b0; wrData = 36'hD_EADB_EEF0;
    advOp(4'h0);
    check("R4", rdData, model[17]);
    advOp(4'h0);
    check("R4", rdData, model[18]);
    rdWrN = 1'b1;
    loadOp(17, 1'b0, 4'hF);
    check("R4", rdData, model[17]);

    // R9: output enable gating
    loadOp(24, 1'b0, 4'hF);
    outEnN = 1'b1; #0.5;
    check("R9", rdData, 36'h0);
    outEnN = 1'b0; #0.5;
    check("R9", rdData, model[24]);

    // R10: advances after a deselect start nothing
    loadOp(40, 1'b0, 4'hF);
    deselOp(0);
    rdWrN = 1'b0; wrData = 36'h7_7777_7777;
    advOp(4'h0);
    check("R10", rdData, 36'h0);
    advOp(4'h0);
    check("R10", rdData, 36'h0);
    rdWrN = 1'b1;
    readBurst(40, 1'b1);

    // R11: each select input ends a burst
    for (int v = 0; v < 3; v++) begin
      loadOp(20, 1'b0, 4'hF);
      advOp(4'hF);
      check("R11", rdData, model[21]);
      deselOp(v);
      check("R11", rdData, 36'h0);
      advOp(4'hF);
      check("R11", rdData, 36'h0);
    end

    // R12: reset during a read
    loadOp(33, 1'b0, 4'hF);
    rstN = 1'b0;
    tick();
    check("R12", rdData, 36'h0);
    rstN = 1'b1;
    advOp(4'hF);
    check("R12", rdData, 36'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule